// File: doc/BRIEF.md
# Pattern and Nametable Bank Address Generator

This block turns the upper lines of the picture-processor address bus into a banked address for the character memory, and decides whether each access goes to the character ROM or to the internal nametable RAM. Its inputs are PPU address lines A10 to A13, eight latched character bank registers of 8 bits each, and the six low bits of the banking-style register. Its outputs are the bank lines (character address A10 and up), a ROM enable, a nametable-RAM enable and the A10 line for that RAM.

The style value holds four fields. Bits 1:0 pick one of four addressing modes, and these modes mix 1 KB and 2 KB pattern slices in different ways. Bits 3:2 are the mirroring field. Bit 4 picks where nametables come from. Bit 5 picks where bank bit 0 comes from: either the latched register or a mirroring rule, and the rule is different in each mode.

The path is purely combinational. A new PPU address gives its bank lines and enables within the same cycle. The bank registers are loaded elsewhere, by the CPU write decoder.

Top module: `chr_nt_addr_gen`

## Requirements
- R1: Mode 0 (style[1:0]=0), pattern region (A13=0): the bank equals register number {A12,A11,A10}, one 1 KB slice per register.
- R2: Mode 1, pattern region: register {A12,A11} gives the bank. Bits 7:1 of the bank come from that register.
- R3: Modes 2 and 3, pattern region: with A12=0, register {A11,A10} gives a 1 KB bank. With A12=1, register 4+A11 gives a 2 KB slice, and bits 7:1 of the bank come from that register.
- R4: In every 2 KB pattern slice, bank bit 0 equals PPU A10 when style[5]=1. It equals bit 0 of the register when style[5]=0.
- R5: Mode 0, nametable region (A13=1): bank bits 7:1 come from register 6+A11 when style[2]=0, and from register 6+A10 when style[2]=1.
- R6: Mode 0 nametables, bank bit 0: with style[5]=0 it is bit 0 of the chosen register. With style[5]=1 it follows style[3:2]: 0 gives A10, 1 gives A11, 2 gives 0, 3 gives 1.
- R7: Mode 1 nametables: the bank equals register 4+{A11,A10}, unmodified, whatever style[5:2] holds.
- R8: Mode 2 nametables: the bank equals register 6+A10 when style[2]=0, and register 6+A11 when style[2]=1. style[3] and style[5] do not change it. Equal values in registers 6 and 7 give a single screen.
- R9: Mode 3 nametables: the same as mode 2 when style[5]=0. With style[5]=1, bank bit 0 follows style[3:2]: 0 gives A11, 1 gives A10, 2 gives 1, 3 gives 0.
- R10: In the pattern region, the ROM enable is 1 and the RAM enable is 0. In the nametable region, style[4]=1 enables the ROM only, and style[4]=0 enables the RAM only. The RAM's A10 line equals bank bit 0.
- R11: In the nametable region, A12 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ppu_addr_hi | input | 4 | PPU address lines A13..A10 (bit 0 is A10) |
| chr_sel | input | 8*BANK_W | Bank registers 0..7, register n at bits [n*BANK_W +: BANK_W] |
| style | input | 6 | Banking style: [1:0] mode, [3:2] mirroring, [4] nametable source, [5] bit-0 rule |
| chr_bank_addr | output | BANK_W | Character memory address A10 and up |
| chr_rom_ce | output | 1 | Character ROM enable, active high |
| ciram_ce | output | 1 | Internal nametable RAM enable, active high |
| ciram_a10 | output | 1 | A10 line for the nametable RAM |

## Verification
The embedded immediate assertions assume that every input is a known 0 or 1 and that each input changes only once per cycle. They check only settled combinational values. To stay within that, the stimulus changes the address, the style and the register contents just after a rising edge, and the outputs are compared at the falling edge. The stimulus walks every style value against every address code, using two register sets whose bit-0 values differ. It then adds directed cases for single-screen nametables, in which registers 6 and 7 hold the same value.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

   localparam int NSEL = 8;

   typedef enum logic [1:0] {
      MAP_FINE      = 2'd0,
      MAP_WIDE      = 2'd1,
      MAP_SPLIT     = 2'd2,
      MAP_SPLIT_MIR = 2'd3
   } map_mode_e;

   // bit-0 selection by mirroring field under the mode-0 table
   function automatic logic mir_a10(input logic [1:0] m, input logic a10, input logic a11);
      logic r;
      case (m)
         2'd0:    r = a10;
         2'd1:    r = a11;
         2'd2:    r = 1'b0;
         default: r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/chr_pat_map.sv
module chr_pat_map
   import chr_map_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic [2:0]                  slot,
   input  logic [NSEL-1:0][BANK_W-1:0] sel,
   input  map_mode_e                   mode,
   input  logic                        a10_rule,
   output logic [BANK_W-1:0]           bank
);

   logic [2:0]        idx;
   logic              wide;
   logic [BANK_W-1:0] raw;

   always_comb begin
      unique case (mode)
         MAP_FINE: begin
            idx  = slot;
            wide = 1'b0;
         end
         MAP_WIDE: begin
            idx  = {1'b0, slot[2:1]};
            wide = 1'b1;
         end
         default: begin
            if (!slot[2]) begin
               idx  = {1'b0, slot[1:0]};
               wide = 1'b0;
            end else begin
               idx  = {2'b10, slot[1]};
               wide = 1'b1;
            end
         end
      endcase
      raw  = sel[idx];
      bank = raw;
      if (wide && a10_rule) bank[0] = slot[0];
   end

   always_comb begin
      // R2
      if (mode == MAP_WIDE)
         wide_upper_chk: assert (bank[BANK_W-1:1] == sel[{1'b0, slot[2:1]}][BANK_W-1:1]);
      // R4
      if (wide && !a10_rule)
         wide_latched_chk: assert (bank[0] == raw[0]);
   end

endmodule

// File: rtl/chr_nt_map.sv
module chr_nt_map
   import chr_map_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic                   a10,
   input  logic                   a11,
   input  logic [3:0][BANK_W-1:0] sel_hi,
   input  map_mode_e              mode,
   input  logic [1:0]             mir,
   input  logic                   a10_rule,
   output logic [BANK_W-1:0]      bank
);

   logic pick;

   always_comb begin
      pick = 1'b0;
      unique case (mode)
         MAP_FINE: begin
            pick = mir[0] ? a10 : a11;
            bank = sel_hi[{1'b1, pick}];
            if (a10_rule) bank[0] = mir_a10(mir, a10, a11);
         end
         MAP_WIDE: begin
            bank = sel_hi[{a11, a10}];
         end
         MAP_SPLIT: begin
            pick = mir[0] ? a11 : a10;
            bank = sel_hi[{1'b1, pick}];
         end
         default: begin
            pick = mir[0] ? a11 : a10;
            bank = sel_hi[{1'b1, pick}];
            if (a10_rule) bank[0] = mir_a10(mir ^ 2'b01, a10, a11);
         end
      endcase
   end

   always_comb begin
      // R8
      if (mode == MAP_SPLIT)
         split_src_chk: assert (bank == sel_hi[2] || bank == sel_hi[3]);
      // R7
      if (mode == MAP_WIDE)
         wide_nt_chk: assert (bank == sel_hi[{a11, a10}]);
   end

endmodule

// File: rtl/chr_nt_addr_gen.sv
module chr_nt_addr_gen
   import chr_map_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic [3:0]             ppu_addr_hi,
   input  logic [NSEL*BANK_W-1:0] chr_sel,
   input  logic [5:0]             style,
   output logic [BANK_W-1:0]      chr_bank_addr,
   output logic                   chr_rom_ce,
   output logic                   ciram_ce,
   output logic                   ciram_a10
);

   generate
      if (BANK_W < 2) begin : g_bad_width
         $error("BANK_W must be at least 2");
      end
   endgenerate

   logic [NSEL-1:0][BANK_W-1:0] sel_arr;
   logic [BANK_W-1:0]           pat_bank;
   logic [BANK_W-1:0]           nt_bank;
   logic                        in_nt;
   map_mode_e                   mode;

   generate
      for (genvar g = 0; g < NSEL; g++) begin : g_unpack
         assign sel_arr[g] = chr_sel[g*BANK_W +: BANK_W];
      end
   endgenerate

   assign mode  = map_mode_e'(style[1:0]);
   assign in_nt = ppu_addr_hi[3];

   chr_pat_map #(.BANK_W(BANK_W)) u_pat (
      .slot     (ppu_addr_hi[2:0]),
      .sel      (sel_arr),
      .mode     (mode),
      .a10_rule (style[5]),
      .bank     (pat_bank)
   );

   chr_nt_map #(.BANK_W(BANK_W)) u_nt (
      .a10      (ppu_addr_hi[0]),
      .a11      (ppu_addr_hi[1]),
      .sel_hi   (sel_arr[7:4]),
      .mode     (mode),
      .mir      (style[3:2]),
      .a10_rule (style[5]),
      .bank     (nt_bank)
   );

   assign chr_bank_addr = in_nt ? nt_bank : pat_bank;
   assign chr_rom_ce    = !in_nt || style[4];
   assign ciram_ce      = in_nt && !style[4];
   assign ciram_a10     = nt_bank[0];

   always_comb begin
      // R10
      ce_excl_chk: assert ($countones({chr_rom_ce, ciram_ce}) == 1);
      // R10
      if (ciram_ce)
         ciram_a10_chk: assert (ciram_a10 == chr_bank_addr[0]);
      // R1
      if (!in_nt && mode == MAP_FINE)
         fine_pat_chk: assert (chr_bank_addr == sel_arr[ppu_addr_hi[2:0]]);
   end

endmodule

// File: tb/chr_nt_addr_gen_test.sv
`timescale 1ns/1ps
module chr_nt_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ppu_addr_hi = '0;
   logic [63:0] chr_sel = '0;
   logic [5:0]  style = '0;
   logic [7:0]  chr_bank_addr;
   logic        chr_rom_ce, ciram_ce, ciram_a10;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] a;
      logic [5:0] st;
      logic [7:0] bank;
      logic       rom;
      logic       ci;
      string      tag;
   } exp_t;

   exp_t sb[$];
   logic [7:0] sregs [8];

   always #2.5 clk = ~clk;

   chr_nt_addr_gen uut (
      .ppu_addr_hi   (ppu_addr_hi),
      .chr_sel       (chr_sel),
      .style         (style),
      .chr_bank_addr (chr_bank_addr),
      .chr_rom_ce    (chr_rom_ce),
      .ciram_ce      (ciram_ce),
      .ciram_a10     (ciram_a10)
   );

   function automatic exp_t model(input logic [3:0] a, input logic [5:0] st);
      exp_t e;
      logic [7:0] r;
      logic lo;
      logic a10 = a[0], a11 = a[1], a12 = a[2], a13 = a[3];
      logic h = st[2], v = st[3], rule = st[5];
      e.a = a; e.st = st;
      if (!a13) begin
         case (st[1:0])
            2'd0: begin e.bank = sregs[a[2:0]]; e.tag = "R1"; end
            2'd1: begin
               r = sregs[{1'b0, a[2:1]}];
               e.bank = {r[7:1], rule ? a10 : r[0]};
               e.tag = rule ? "R4" : "R2";
            end
            default: begin
               if (!a12) begin e.bank = sregs[{1'b0, a[1:0]}]; e.tag = "R3"; end
               else begin
                  r = sregs[a11 ? 5 : 4];
                  e.bank = {r[7:1], rule ? a10 : r[0]};
                  e.tag = rule ? "R4" : "R3";
               end
            end
         endcase
      end else begin
         case (st[1:0])
            2'd0: begin
               r = h ? sregs[a10 ? 7 : 6] : sregs[a11 ? 7 : 6];
               if (!rule) lo = r[0];
               else if (v) lo = h;
               else lo = h ? a11 : a10;
               e.bank = {r[7:1], lo};
               e.tag = rule ? "R6" : "R5";
            end
            2'd1: begin
               e.bank = sregs[4 + 2*a11 + a10];
               e.tag = "R7";
            end
            default: begin
               r = h ? sregs[a11 ? 7 : 6] : sregs[a10 ? 7 : 6];
               lo = r[0];
               if (st[1:0] == 2'd3 && rule) begin
                  if (v) lo = !h;
                  else lo = h ? a10 : a11;
               end
               e.bank = {r[7:1], lo};
               e.tag = (st[1:0] == 2'd3) ? "R9" : "R8";
            end
         endcase
         if (a12) e.tag = {e.tag, "/R11"};
      end
      e.rom = !a13 || st[4];
      e.ci  = a13 && !st[4];
      return e;
   endfunction

   task automatic load_regs(input logic [7:0] base, input logic [7:0] step);
      @(posedge clk);
      #1;
      for (int i = 0; i < 8; i++) begin
         sregs[i] = base + step * i[7:0];
         chr_sel[i*8 +: 8] = sregs[i];
      end
   endtask

   task automatic drive(input logic [3:0] a, input logic [5:0] st);
      @(posedge clk);
      #1;
      ppu_addr_hi = a;
      style = st;
      sb.push_back(model(a, st));
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [7:0] got, input logic [7:0] exp,
                        input logic [3:0] a, input logic [5:0] st);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s addr=%h style=%h got=%h exp=%h", tag, what, a, st, got, exp);
      end
   endtask

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(chr_bank_addr == e.bank, e.tag, "bank", chr_bank_addr, e.bank, e.a, e.st);
         check(chr_rom_ce == e.rom, "R10", "rom_ce", {7'd0, chr_rom_ce}, {7'd0, e.rom}, e.a, e.st);
         check(ciram_ce == e.ci, "R10", "ciram_ce", {7'd0, ciram_ce}, {7'd0, e.ci}, e.a, e.st);
         if (e.ci)
            check(ciram_a10 == e.bank[0], "R10", "ciram_a10", {7'd0, ciram_a10}, {7'd0, e.bank[0]}, e.a, e.st);
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) sregs[i] = 8'h00;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero inputs, R1 pattern access
      drive(4'h0, 6'h00);
      // two register sets with differing bit-0 patterns
      load_regs(8'h05, 8'h25);
      for (int st = 0; st < 64; st++)
         for (int a = 0; a < 16; a++)
            drive(a[3:0], st[5:0]);
      load_regs(8'hFA, 8'hDB);
      for (int st = 0; st < 64; st++)
         for (int a = 0; a < 16; a++)
            drive(a[3:0], st[5:0]);
      // R8 single screen: registers 6 and 7 equal
      load_regs(8'h5A, 8'h00);
      for (int a = 8; a < 16; a++) begin
         drive(a[3:0], 6'h02);
         drive(a[3:0], 6'h26);
         drive(a[3:0], 6'h1A);
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule